// File: doc/BRIEF.md
# Differential Clock Output Gating Controller

This block decides, cycle by cycle, whether each of a set of differential clock pairs and one single-ended reference output is running or parked in a stopped state. A pair runs only when four conditions hold together: the PLL reports lock, the device is out of power-down, the pair's register enable bit hands control to its pin, and the pin sits at its programmed active level. A stopped pair drives the levels that a shared 2-bit stop code selects for its true and complement legs.

The asynchronous inputs (enable pins, lock and power-good) pass through a two-stage synchronizer into the output clock domain. The per-output run flag is updated on the falling edge of the clock. Each output therefore starts and stops only at a clean boundary, and its gated clock copy never carries a shortened pulse. The reference output stays high-impedance until power-good is seen high for the first time. After that it runs under its own enable bit, and during power-down it keeps running only if the wake-on-LAN bit is set.

Drive codes on every leg use this encoding: 00 = driven low, 01 = driven high, 10 = high-impedance, 11 = running clock.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: When a pair's register enable bit is 0, the pair is stopped whatever its pin level. When the bit is 1, the pin decides.
- R2: When a pair's polarity bit is 0, the pair is enabled while its pin is low. When the bit is 1, the pair is enabled while its pin is high.
- R3: A stopped pair drives true/complement codes chosen by the stop code: 00 gives low/low, 01 gives high-Z/high-Z, 10 gives high/low, 11 gives low/high. A running pair drives code 11 on both legs.
- R4: No pair runs while the PLL lock input is low.
- R5: After an enable pin or a register enable bit changes, the pair's drive code follows within 1 to 3 rising clock edges, both when starting and when stopping.
- R6: While power-good is low, every pair is stopped. The reference output runs only if the wake-on-LAN bit is 1, and drives low otherwise.
- R7: The reference output drives high-Z from reset until power-good has been high once. It never returns to high-Z after that, even in power-down.
- R8: Once out of the high-Z state, the reference output drives low when its enable bit is 0 and runs when the bit is 1 and it is not held off by power-down.
- R9: Each gated clock output follows the input clock while its output is running and stays low while it is stopped. The run state changes only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Output clock to be gated |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pll_lock_i | input | 1 | PLL lock status (asynchronous) |
| pwrgd_i | input | 1 | Power-good; low requests power-down (asynchronous) |
| en_pin_i | input | NPAIR | Per-pair enable pins (asynchronous) |
| pin_pol_i | input | NPAIR | Per-pair pin active level, 1 = active high |
| reg_en_i | input | NPAIR | Per-pair register enable, 0 forces stop |
| stop_code_i | input | 2 | Stopped-state leg levels |
| wol_en_i | input | 1 | Keep reference running in power-down |
| ref_en_i | input | 1 | Reference output enable |
| drv_t_o | output | 2*NPAIR | True-leg drive code per pair |
| drv_c_o | output | 2*NPAIR | Complement-leg drive code per pair |
| gclk_o | output | NPAIR | Gated clock per pair |
| ref_drv_o | output | 2 | Reference output drive code |
| ref_clk_o | output | 1 | Gated reference clock |

## Verification
The hardest situation to reach from the ports is the exact latency window. A pin edge travels through two synchronizer flops and a falling-edge flop, while a register bit reaches only the falling-edge flop, so the two paths give different edge counts. To measure both, the bench changes each input just after a falling edge and counts rising edges until the drive code moves, in both the start and the stop direction. The rest of the bench rotates every pin, polarity and enable combination across the eight pairs at once. It also changes the stop code in each round, so all four stopped encodings appear next to running pairs.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;

  typedef enum logic [1:0] {
    DRV_LOW  = 2'b00,
    DRV_HIGH = 2'b01,
    DRV_HIZ  = 2'b10,
    DRV_RUN  = 2'b11
  } drv_e;

  typedef struct packed {
    drv_e t;
    drv_e c;
  } leg_pair_t;

  function automatic leg_pair_t stop_legs(input logic [1:0] code);
    leg_pair_t r;
    case (code)
      2'b00:   begin r.t = DRV_LOW;  r.c = DRV_LOW;  end
      2'b01:   begin r.t = DRV_HIZ;  r.c = DRV_HIZ;  end
      2'b10:   begin r.t = DRV_HIGH; r.c = DRV_LOW;  end
      default: begin r.t = DRV_LOW;  r.c = DRV_HIGH; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clkout_gate_sync.sv
module clkout_gate_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkout_gate_leg.sv
module clkout_gate_leg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  output logic run_o,
  output logic gclk_o
);
  logic run_q;

  // falling-edge update: run only moves while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else run_q <= want_i;
  end

  assign run_o  = run_q;
  assign gclk_o = clk_i & run_q;
endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
  import clkout_gate_pkg::*;
#(
  parameter int NPAIR       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pll_lock_i,
  input  logic               pwrgd_i,
  input  logic [NPAIR-1:0]   en_pin_i,
  input  logic [NPAIR-1:0]   pin_pol_i,
  input  logic [NPAIR-1:0]   reg_en_i,
  input  logic [1:0]         stop_code_i,
  input  logic               wol_en_i,
  input  logic               ref_en_i,
  output logic [2*NPAIR-1:0] drv_t_o,
  output logic [2*NPAIR-1:0] drv_c_o,
  output logic [NPAIR-1:0]   gclk_o,
  output logic [1:0]         ref_drv_o,
  output logic               ref_clk_o
);
  localparam int SW = NPAIR + 2;

  logic [SW-1:0]    async_in, sync_q;
  logic [NPAIR-1:0] pin_s, pin_act, want, run;
  logic             lock_s, pwr_s, pg_seen_q, ref_want, ref_run;
  leg_pair_t        stop_lv;

  assign async_in = {pwrgd_i, pll_lock_i, en_pin_i};

  clkout_gate_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (async_in),
    .q_o    (sync_q)
  );

  assign pin_s  = sync_q[NPAIR-1:0];
  assign lock_s = sync_q[NPAIR];
  assign pwr_s  = sync_q[NPAIR+1];

  // sticky: reference leaves high-Z on first power-good
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pg_seen_q <= 1'b0;
    else if (pwr_s) pg_seen_q <= 1'b1;
  end

  assign pin_act = ~(pin_s ^ pin_pol_i);
  assign want    = pin_act & reg_en_i & {NPAIR{lock_s & pwr_s}};
  assign stop_lv = stop_legs(stop_code_i);

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    clkout_gate_leg u_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .want_i (want[i]),
      .run_o  (run[i]),
      .gclk_o (gclk_o[i])
    );
    assign drv_t_o[2*i +: 2] = run[i] ? DRV_RUN : stop_lv.t;
    assign drv_c_o[2*i +: 2] = run[i] ? DRV_RUN : stop_lv.c;
  end

  assign ref_want = pg_seen_q & ref_en_i & (pwr_s | wol_en_i);

  clkout_gate_leg u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .want_i (ref_want),
    .run_o  (ref_run),
    .gclk_o (ref_clk_o)
  );

  assign ref_drv_o = !pg_seen_q ? DRV_HIZ : (ref_run ? DRV_RUN : DRV_LOW);
endmodule

// File: rtl/clkout_gate_chk.sv
module clkout_gate_chk #(
  parameter int NPAIR = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pll_lock_i,
  input logic               pwrgd_i,
  input logic [NPAIR-1:0]   reg_en_i,
  input logic [1:0]         stop_code_i,
  input logic               ref_en_i,
  input logic [2*NPAIR-1:0] drv_t_o,
  input logic [2*NPAIR-1:0] drv_c_o,
  input logic [NPAIR-1:0]   gclk_o,
  input logic [1:0]         ref_drv_o
);
  logic [2:0] lock_lo_cnt, pg_lo_cnt;
  logic       pg_seen;
  logic       any_run;
  logic [1:0] exp_t, exp_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_lo_cnt <= '0;
      pg_lo_cnt   <= '0;
      pg_seen     <= 1'b0;
    end else begin
      lock_lo_cnt <= pll_lock_i ? 3'd0 : (lock_lo_cnt == 3'd7 ? 3'd7 : lock_lo_cnt + 3'd1);
      pg_lo_cnt   <= pwrgd_i ? 3'd0 : (pg_lo_cnt == 3'd7 ? 3'd7 : pg_lo_cnt + 3'd1);
      if (pwrgd_i) pg_seen <= 1'b1;
    end
  end

  always_comb begin
    any_run = 1'b0;
    for (int i = 0; i < NPAIR; i++) any_run |= (drv_t_o[2*i +: 2] == 2'b11);
    case (stop_code_i)
      2'b00:   begin exp_t = 2'b00; exp_c = 2'b00; end
      2'b01:   begin exp_t = 2'b10; exp_c = 2'b10; end
      2'b10:   begin exp_t = 2'b01; exp_c = 2'b00; end
      default: begin exp_t = 2'b00; exp_c = 2'b01; end
    endcase
  end

  AST_NO_RUN_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_lo_cnt >= 3'd3) |-> !any_run); // R4

  AST_PD_STOPS_PAIRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pg_lo_cnt >= 3'd3) |-> !any_run); // R6

  AST_REF_HIZ_BEFORE_PG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg_seen |-> (ref_drv_o == 2'b10)); // R7

  AST_REF_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_en_i && $past(!ref_en_i)) |-> (ref_drv_o != 2'b11)); // R8

  for (genvar i = 0; i < NPAIR; i++) begin : g_chk
    AST_REG_OFF_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!reg_en_i[i] && $past(!reg_en_i[i])) |-> (drv_t_o[2*i +: 2] != 2'b11)); // R1

    AST_STOP_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drv_t_o[2*i +: 2] != 2'b11) |->
        (drv_t_o[2*i +: 2] == exp_t && drv_c_o[2*i +: 2] == exp_c)); // R3

    AST_GCLK_MATCHES_RUN: assert property (@(negedge clk_i) disable iff (!rst_ni)
      gclk_o[i] == (drv_t_o[2*i +: 2] == 2'b11)); // R9
  end
endmodule

bind clkout_gate_ctrl clkout_gate_chk #(.NPAIR(NPAIR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pll_lock_i  (pll_lock_i),
  .pwrgd_i     (pwrgd_i),
  .reg_en_i    (reg_en_i),
  .stop_code_i (stop_code_i),
  .ref_en_i    (ref_en_i),
  .drv_t_o     (drv_t_o),
  .drv_c_o     (drv_c_o),
  .gclk_o      (gclk_o),
  .ref_drv_o   (ref_drv_o)
);

// File: tb/tb_clkout_gate_ctrl.sv
module tb_clkout_gate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            pll_lock_i = 1'b0, pwrgd_i = 1'b0;
  logic [NP-1:0]   en_pin_i = '0, pin_pol_i = '0, reg_en_i = '1;
  logic [1:0]      stop_code_i = 2'b00;
  logic            wol_en_i = 1'b0, ref_en_i = 1'b1;
  logic [2*NP-1:0] drv_t_o, drv_c_o;
  logic [NP-1:0]   gclk_o;
  logic [1:0]      ref_drv_o;
  logic            ref_clk_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkout_gate_ctrl #(.NPAIR(NP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pll_lock_i(pll_lock_i), .pwrgd_i(pwrgd_i),
    .en_pin_i(en_pin_i), .pin_pol_i(pin_pol_i), .reg_en_i(reg_en_i),
    .stop_code_i(stop_code_i), .wol_en_i(wol_en_i), .ref_en_i(ref_en_i),
    .drv_t_o(drv_t_o), .drv_c_o(drv_c_o), .gclk_o(gclk_o),
    .ref_drv_o(ref_drv_o), .ref_clk_o(ref_clk_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // R3 encoding: 00 low, 01 high, 10 high-Z, 11 run
  function automatic logic [1:0] st_t(input logic [1:0] c);
    return (c == 2'b01) ? 2'b10 : (c == 2'b10) ? 2'b01 : 2'b00;
  endfunction
  function automatic logic [1:0] st_c(input logic [1:0] c);
    return (c == 2'b01) ? 2'b10 : (c == 2'b11) ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [2*NP-1:0] exp_vec(input logic [NP-1:0] run, input bit tleg,
                                             input logic [1:0] c);
    logic [2*NP-1:0] v;
    for (int i = 0; i < NP; i++)
      v[2*i +: 2] = run[i] ? 2'b11 : (tleg ? st_t(c) : st_c(c));
    return v;
  endfunction

  task automatic check_pairs(input string req, input logic [NP-1:0] run);
    chk(req, drv_t_o, exp_vec(run, 1'b1, stop_code_i));
    chk(req, drv_c_o, exp_vec(run, 1'b0, stop_code_i));
  endtask

  // count rising edges until pair 0 reaches the wanted run state
  task automatic latency(input string req, input bit use_pin, input bit val, input bit want_run);
    int n = 0;
    bit hit = 1'b0;
    @(negedge clk); #1;
    if (use_pin) en_pin_i[0] = val; else reg_en_i[0] = val;
    for (int k = 1; k <= 8 && !hit; k++) begin
      @(posedge clk); #1;
      n = k;
      if ((drv_t_o[1:0] == 2'b11) == want_run) hit = 1'b1;
    end
    chk(req, {31'd0, (n >= 1 && n <= 3 && hit)}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_ni = 1'b1;
    tick(3);
    // reset state
    check_pairs("R3 reset stop low/low", '0);
    chk("R7 reset ref high-Z", ref_drv_o, 2'b10);
    chk("R9 reset gclk", gclk_o, '0);

    // pins active (low, pol 0) but no lock, no power-good
    tick(4);
    check_pairs("R4 no lock no pg", '0);
    chk("R7 ref high-Z before pg", ref_drv_o, 2'b10);

    pwrgd_i = 1'b1;
    tick(5);
    check_pairs("R4 pg without lock", '0);
    chk("R8 ref runs after pg", ref_drv_o, 2'b11);

    pll_lock_i = 1'b1;
    tick(5);
    check_pairs("R1 R2 all enabled", '1);

    // sweep pin/polarity/enable per pair; stop code rotates
    for (int r = 0; r < 8; r++) begin
      logic [NP-1:0] exp_run;
      for (int i = 0; i < NP; i++) begin
        logic [2:0] v;
        v = 3'((r + i) & 7);
        en_pin_i[i]  = v[0];
        pin_pol_i[i] = v[1];
        reg_en_i[i]  = v[2];
        exp_run[i]   = v[2] & (v[0] == v[1]);
      end
      stop_code_i = 2'(r);
      tick(5);
      for (int i = 0; i < NP; i++) begin
        chk($sformatf("R1 R2 R3 round %0d pair %0d t", r, i), drv_t_o[2*i +: 2],
            exp_run[i] ? 2'b11 : st_t(stop_code_i));
        chk($sformatf("R3 round %0d pair %0d c", r, i), drv_c_o[2*i +: 2],
            exp_run[i] ? 2'b11 : st_c(stop_code_i));
      end
      // gated clocks: high phase follows run, low phase zero
      @(posedge clk); #2;
      chk($sformatf("R9 high phase round %0d", r), gclk_o, exp_run);
      @(negedge clk); #2;
      chk($sformatf("R9 low phase round %0d", r), gclk_o, '0);
    end

    // latency, both paths, both directions
    en_pin_i = '0; pin_pol_i = '0; reg_en_i = '1; stop_code_i = 2'b00;
    tick(5);
    latency("R5 pin stop", 1'b1, 1'b1, 1'b0);
    tick(3);
    latency("R5 pin start", 1'b1, 1'b0, 1'b1);
    tick(3);
    latency("R5 reg stop", 1'b0, 1'b0, 1'b0);
    tick(3);
    latency("R5 reg start", 1'b0, 1'b1, 1'b1);
    tick(3);

    // lock loss
    pll_lock_i = 1'b0;
    tick(5);
    check_pairs("R4 lock lost", '0);
    chk("R8 ref unaffected by lock", ref_drv_o, 2'b11);
    pll_lock_i = 1'b1;
    tick(5);
    check_pairs("R4 lock back", '1);

    // power-down, wake-on-LAN off then on
    stop_code_i = 2'b10;
    pwrgd_i = 1'b0;
    tick(5);
    check_pairs("R6 pd pairs stop", '0);
    chk("R6 R7 pd ref low not high-Z", ref_drv_o, 2'b00);
    @(posedge clk); #2;
    chk("R9 ref clk gated", {31'd0, ref_clk_o}, 32'd0);
    wol_en_i = 1'b1;
    tick(5);
    chk("R6 pd ref runs with wol", ref_drv_o, 2'b11);
    @(posedge clk); #2;
    chk("R9 ref clk follows", {31'd0, ref_clk_o}, 32'd1);
    check_pairs("R6 pd pairs stop with wol", '0);

    // reference enable bit
    pwrgd_i = 1'b1; wol_en_i = 1'b0;
    tick(5);
    check_pairs("R6 pd exit", '1);
    ref_en_i = 1'b0;
    tick(3);
    chk("R8 ref disabled", ref_drv_o, 2'b00);
    ref_en_i = 1'b1;
    tick(3);
    chk("R8 ref re-enabled", ref_drv_o, 2'b11);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule